// File: doc/BRIEF.md
# Recursive Quadrant Unsigned Multiplier

This block multiplies two unsigned operands and returns the full-width product in the same cycle. It has no clock and no state. The product is built by divide and conquer. An operand pair of width N is split into low and high halves. Four half-width multipliers form the cross terms, and those terms are merged by adders. The recursion ends at a 2x2 cell written directly in gates. All four sub-products of a level are formed in parallel, and only then are they added. Rows are never accumulated one after another.

The `KIND` parameter chooses which adder performs every merge addition: ripple-carry, carry-skip or carry-lookahead. The carry-lookahead setting is the default and the fastest. The same module works at any power-of-two width from 2 upward, so 4x4 and 8x8 multipliers can be placed on their own.

At each level of width N, with half width H, the sub-products are named by which operand halves they use (low or high). The merge works in three steps:
- The low H bits of LL go straight to the product.
- A middle sum LH + HL + (LL >> H) is formed with full carry.
- The top N product bits are HH plus the high part of the middle sum.

Top module: `vc_mult`

## Requirements
- R1: For WIDTH=16, `prod` equals the unsigned product `op_a * op_b` in all 32 bits, with nothing truncated.
- R2: The 2x2 base cell gives:
  - bit 0 = a0&b0
  - bit 1 = (a1&b0)^(a0&b1)
  - bit 2 = (a1&b1)^k
  - bit 3 = (a1&b1)&k
  
  Here k = a1&b0&a0&b1. So a WIDTH=2 instance returns a*b for all 16 input pairs.
- R3: Instances with WIDTH=4 and WIDTH=8 work standalone and return the exact product for every operand pair.
- R4: Every merge adder returns exactly a+b+cin, carry out included. The carry-skip adder passes a block's carry-in straight to its carry-out when all 4 propagate bits of the block are set. The lookahead adder computes carries in flat 4-bit groups, and the carry ripples from one group to the next.
- R5: With KIND=ADD_RIPPLE (encoding 0), the product is exact at widths 2, 4, 8 and 16.
- R6: With KIND=ADD_SKIP (encoding 1), the product is exact at widths 2, 4, 8 and 16.
- R7: With KIND=ADD_LOOKAHEAD (encoding 2), the product is exact at widths 2, 4, 8 and 16.
- R8: If either operand is zero, the product is zero.
- R9: If `op_b` is 1, the product equals `op_a` zero-extended.
- R10: With all operand bits set, the product is exact (0xFFFE0001 at WIDTH=16). No merge level produces a carry out of its middle or upper addition.
- R11: Alternating operand patterns (0xAAAA, 0x5555) give exact products.
- R12: `prod` is a purely combinational function of the operands. It settles within the same clock period in which the operands change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| prod | output | 2*WIDTH | Unsigned product, full width |

## Verification
The in-line checks assume two things. First, the operands are fully known two-state values. Second, WIDTH is a power of two, so every recursion level splits cleanly in half. The checks are immediate and combinational, so they also rely on the inputs being held steady until the whole adder tree has settled. The stimulus changes the operands only on a rising edge and reads the product half a period later, on the falling edge. It drives every instance from the same pair of known operand buses.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ADD_RIPPLE    = 2'd0,
    ADD_SKIP      = 2'd1,
    ADD_LOOKAHEAD = 2'd2
  } adder_kind_e;

  localparam int GROUP_BITS = 4;
endpackage

// File: rtl/vc_adder.sv
module vc_adder
  import vc_pkg::*;
#(
  parameter int          W    = 8,
  parameter adder_kind_e KIND = ADD_LOOKAHEAD
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int GRP = GROUP_BITS;

  generate
    if (KIND == ADD_RIPPLE) begin : g_ripple
      always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < W; i++) begin
          sum[i] = a[i] ^ b[i] ^ c;
          c      = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        cout = c;
      end
    end else if (KIND == ADD_SKIP) begin : g_skip
      // 4-bit blocks ripple inside; an all-propagate block forwards its carry-in
      always_comb begin
        logic c;
        logic blk_cin;
        logic blk_prop;
        c        = cin;
        blk_cin  = cin;
        blk_prop = 1'b1;
        for (int i = 0; i < W; i++) begin
          if (i % GRP == 0) begin
            blk_cin  = c;
            blk_prop = 1'b1;
          end
          sum[i]   = a[i] ^ b[i] ^ c;
          blk_prop = blk_prop & (a[i] ^ b[i]);
          c        = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
          if ((i % GRP == GRP - 1) || (i == W - 1))
            c = blk_prop ? blk_cin : c;
        end
        cout = c;
      end
    end else begin : g_lookahead
      // flat sum-of-products carries inside each 4-bit group, rippled between groups
      always_comb begin
        logic gc;
        logic ck;
        logic term;
        int   len;
        gc  = cin;
        sum = '0;
        for (int base = 0; base < W; base += GRP) begin
          len = ((W - base) < GRP) ? (W - base) : GRP;
          for (int k = 0; k <= GRP; k++) begin
            if (k <= len) begin
              ck = 1'b0;
              for (int j = -1; j < k; j++) begin
                term = (j < 0) ? gc : (a[base+j] & b[base+j]);
                for (int m = j + 1; m < k; m++)
                  term = term & (a[base+m] ^ b[base+m]);
                ck = ck | term;
              end
              if (k < len) sum[base+k] = a[base+k] ^ b[base+k] ^ ck;
              else         gc = ck;
            end
          end
        end
        cout = gc;
      end
    end
  endgenerate

  always_comb begin
    assert_adder_exact_R4 : assert ({cout, sum} ==
      ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("adder result differs from a+b+cin");
  end
endmodule

// File: rtl/vc_cell2.sv
module vc_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic x_term, y_term, hi_term, carry;

  always_comb begin
    x_term  = a[1] & b[0];
    y_term  = a[0] & b[1];
    hi_term = a[1] & b[1];
    carry   = x_term & y_term;
    p[0]    = a[0] & b[0];
    p[1]    = x_term ^ y_term;
    p[2]    = hi_term ^ carry;
    p[3]    = hi_term & carry;
  end

  always_comb begin
    assert_cell_product_R2 : assert (p == ({2'b00, a} * {2'b00, b}))
      else $error("2x2 cell product wrong");
  end
endmodule

// File: rtl/vc_node.sv
module vc_node
  import vc_pkg::*;
#(
  parameter int          N    = 16,
  parameter adder_kind_e KIND = ADD_LOOKAHEAD
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  generate
    if (N == 2) begin : g_leaf
      vc_cell2 u_cell (.a(a), .b(b), .p(p));
    end else begin : g_split
      localparam int H = N / 2;

      logic [N-1:0] ll, lh, hl, hh;
      logic [N-1:0] cross_sum;
      logic         cross_c;
      logic [N:0]   mid;
      logic         mid_c;
      logic         top_c;

      vc_node #(.N(H), .KIND(KIND)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
      vc_node #(.N(H), .KIND(KIND)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(lh));
      vc_node #(.N(H), .KIND(KIND)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(hl));
      vc_node #(.N(H), .KIND(KIND)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(hh));

      vc_adder #(.W(N), .KIND(KIND)) u_cross (
        .a(lh), .b(hl), .cin(1'b0), .sum(cross_sum), .cout(cross_c)
      );

      vc_adder #(.W(N+1), .KIND(KIND)) u_mid (
        .a({cross_c, cross_sum}), .b({{(H+1){1'b0}}, ll[N-1:H]}),
        .cin(1'b0), .sum(mid), .cout(mid_c)
      );

      vc_adder #(.W(N), .KIND(KIND)) u_top (
        .a(hh), .b({{(H-1){1'b0}}, mid[N:H]}),
        .cin(1'b0), .sum(p[2*N-1:N]), .cout(top_c)
      );

      assign p[N-1:0] = {mid[H-1:0], ll[H-1:0]};

      always_comb begin
        assert_no_overflow_R10 : assert (!mid_c && !top_c)
          else $error("merge carried out of its field");
        if ((a == '0) || (b == '0))
          assert_zero_operand_R8 : assert (p == '0)
            else $error("zero operand gave nonzero product");
        if (b == N'(1))
          assert_unit_operand_R9 : assert (p == {{N{1'b0}}, a})
            else $error("multiply by one changed operand");
      end
    end
  endgenerate
endmodule

// File: rtl/vc_mult.sv
module vc_mult
  import vc_pkg::*;
#(
  parameter int          WIDTH = 16,
  parameter adder_kind_e KIND  = ADD_LOOKAHEAD
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] tree_p;

  vc_node #(.N(WIDTH), .KIND(KIND)) u_tree (
    .a(op_a), .b(op_b), .p(tree_p)
  );

  assign prod = tree_p;

  always_comb begin
    if ((op_a == '1) && (op_b == '1))
      assert_all_ones_R10 : assert (prod == {{(WIDTH-1){1'b1}}, 1'b0, {(WIDTH-1){1'b0}}, 1'b1})
        else $error("all-ones product wrong");
  end
endmodule

// File: tb/test_vc_mult.sv
module test_vc_mult;
  import vc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  logic [3:0]  p2  [3];
  logic [7:0]  p4  [3];
  logic [15:0] p8  [3];
  logic [31:0] p16 [3];

  string kind_tag [3] = '{"R5", "R6", "R7"};

  for (genvar k = 0; k < 3; k++) begin : g_kind
    vc_mult #(.WIDTH(2), .KIND(adder_kind_e'(k))) i_vc_mult_w2 (
      .op_a(a_in[1:0]), .op_b(b_in[1:0]), .prod(p2[k]));
    vc_mult #(.WIDTH(4), .KIND(adder_kind_e'(k))) i_vc_mult_w4 (
      .op_a(a_in[3:0]), .op_b(b_in[3:0]), .prod(p4[k]));
    vc_mult #(.WIDTH(8), .KIND(adder_kind_e'(k))) i_vc_mult_w8 (
      .op_a(a_in[7:0]), .op_b(b_in[7:0]), .prod(p8[k]));
    vc_mult #(.WIDTH(16), .KIND(adder_kind_e'(k))) i_vc_mult (
      .op_a(a_in), .op_b(b_in), .prod(p16[k]));
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a_in, b_in, act, exp);
    end
  endtask

  // reference: behavioural multiply at each width, all kinds, every cycle
  task automatic compare_all(input string extra);
    for (int k = 0; k < 3; k++) begin
      chk({kind_tag[k], " R2 w2 ", extra}, {28'b0, p2[k]},
          32'(a_in[1:0]) * 32'(b_in[1:0]));
      chk({kind_tag[k], " R3 w4 ", extra}, {24'b0, p4[k]},
          32'(a_in[3:0]) * 32'(b_in[3:0]));
      chk({kind_tag[k], " R3 w8 ", extra}, {16'b0, p8[k]},
          32'(a_in[7:0]) * 32'(b_in[7:0]));
      chk({kind_tag[k], " R1 w16 ", extra}, p16[k],
          32'(a_in) * 32'(b_in));
    end
  endtask

  // R12: operands change on a rising edge, product read at the next falling edge
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input string extra);
    @(posedge clk);
    a_in = a;
    b_in = b;
    @(negedge clk);
    compare_all(extra);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++)
      chk({kind_tag[k], " R8 reset-state zero"}, p16[k], 32'h0);
    rst_n = 1'b1;

    // exhaustive 8-bit pairs (covers 2x2 and 4x4 fully too)
    for (int i = 0; i < 65536; i++)
      apply({8'h00, 8'(i)}, {8'h00, 8'(i >> 8)}, "R3 exhaustive R12");

    apply(16'h0000, 16'hFFFF, "R8 zero");
    apply(16'hBEEF, 16'h0000, "R8 zero");
    apply(16'hBEEF, 16'h0001, "R9 unit");
    apply(16'hFFFF, 16'h0001, "R9 unit");
    apply(16'h0001, 16'h0001, "R9 unit");
    apply(16'hFFFF, 16'hFFFF, "R10 all ones");
    begin
      for (int k = 0; k < 3; k++)
        chk({kind_tag[k], " R10 literal"}, p16[k], 32'hFFFE0001);
    end
    apply(16'h8000, 16'h8000, "R10 top bits");
    apply(16'hAAAA, 16'h5555, "R11 alternating");
    apply(16'h5555, 16'hAAAA, "R11 alternating");
    apply(16'hAAAA, 16'hAAAA, "R11 alternating");
    apply(16'h5555, 16'h5555, "R11 alternating");
    apply(16'hFF00, 16'h00FF, "R11 halves");

    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), "R1 random");

    finish_run();
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule